// File: doc/BRIEF.md
# Branch and Return Sequencer

This block carries out the control-transfer operations of a small 8-bit processor core that has a 16-bit program counter. The decoder gives it one request at a time. Each request holds an operation kind, a condition code, an immediate operand, the current program counter, the stack pointer, the HL register pair and the zero and carry flags. The block then works out whether the transfer is taken. It returns the next program counter and stack pointer, the number of clock ticks the operation consumed, and that count in machine cycles.

Jumps finish in one step. A taken return pops a 16-bit address from the stack over a byte-wide read port. It takes the low byte first and the high byte second, and waits for a valid strobe on each read. The state machine has six states. IDLE accepts a request. RD_LO and RD_HI each issue one memory read. WAIT_LO and WAIT_HI hold until read data is valid. FIN pulses the done strobe.

The transitions are as follows. IDLE→FIN is taken for any jump and for a return that is not taken. IDLE→RD_LO is taken for a return that is taken. RD_LO→WAIT_LO and RD_HI→WAIT_HI are unconditional. WAIT_LO→RD_HI and WAIT_HI→FIN fire on read valid. FIN→IDLE is unconditional.

Top module: `xfer_seq`

## Requirements
- R1: After reset the block is idle, with done and the read strobe low, and with program counter, stack pointer and tick outputs all zero.
- R2: Condition codes are 0 = always, 1 = zero flag clear, 2 = zero flag set, 3 = carry flag clear and 4 = carry flag set. Codes 5, 6 and 7 are never taken.
- R3: Kind 0 is a relative jump. When taken, the new program counter is the current one plus the low 8 bits of the immediate, read as a signed two's-complement value, wrapping modulo 2^16.
- R4: When taken, kind 1 loads the full 16-bit immediate into the program counter, and kind 2 loads HL into it.
- R5: A jump reports 12 ticks if taken and 8 if not. A jump that is not taken leaves the program counter unchanged. Every jump passes the stack pointer through unchanged.
- R6: Kind 3 is a return. When taken, it reads the byte at SP and then the byte at SP+1, both wrapping. It loads the program counter with {second byte, first byte}, returns SP+2 modulo 2^16 and reports 20 ticks.
- R7: A return that is not taken makes no memory reads, reports 8 ticks and leaves the program counter and stack pointer unchanged.
- R8: The machine-cycle output always equals the tick output divided by four.
- R9: Done is high for exactly one cycle per accepted request, and the result outputs are already valid in that cycle.
- R10: A request presented while the block is not idle is ignored and produces no result.
- R11: Each read waits in its wait state for as many cycles as the read-valid strobe takes to arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_kind | input | 2 | 0 relative, 1 absolute, 2 via HL, 3 return |
| req_cond | input | 3 | Condition code |
| req_imm | input | 16 | Immediate operand (relative jumps use bits 7:0) |
| pc_in | input | 16 | Current program counter |
| sp_in | input | 16 | Current stack pointer |
| hl_in | input | 16 | HL register pair |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| mem_rd_en | output | 1 | One-cycle read request |
| mem_rd_addr | output | 16 | Read address |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 8 | Read data byte |
| idle | output | 1 | Ready for a new request |
| done | output | 1 | Result valid pulse |
| pc_out | output | 16 | New program counter |
| sp_out | output | 16 | New stack pointer |
| ticks | output | 5 | Clock ticks consumed |
| mcyc | output | 3 | Machine cycles consumed |

## Verification
The bench uses the default parameters: a 16-bit address width, 8-bit bytes, and tick counts of 12, 8, 20 and 8. With a 16-bit width, the wrap cases can be reached with only a few requests. These are a relative jump across 0xFFFF in either direction, and a pop that starts at 0xFFFF and continues at 0x0000. The bench memory model can change its read latency, so a slow response exercises both wait states. The 5-bit tick width just holds the longest count, 20.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

    typedef enum logic [1:0] {
        K_JREL = 2'd0,
        K_JABS = 2'd1,
        K_JHL  = 2'd2,
        K_RET  = 2'd3
    } kind_e;

    localparam logic [2:0] CC_ALWAYS = 3'd0;
    localparam logic [2:0] CC_NZ     = 3'd1;
    localparam logic [2:0] CC_Z      = 3'd2;
    localparam logic [2:0] CC_NC     = 3'd3;
    localparam logic [2:0] CC_C      = 3'd4;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RD_LO   = 3'd1,
        ST_WAIT_LO = 3'd2,
        ST_RD_HI   = 3'd3,
        ST_WAIT_HI = 3'd4,
        ST_FIN     = 3'd5
    } state_e;

endpackage

// File: rtl/xfer_cond_eval.sv
module xfer_cond_eval
    import xfer_pkg::*;
(
    input  logic [2:0] cond,
    input  logic       flag_z,
    input  logic       flag_c,
    output logic       taken
);
    always_comb begin
        case (cond)
            CC_ALWAYS: taken = 1'b1;
            CC_NZ:     taken = ~flag_z;
            CC_Z:      taken = flag_z;
            CC_NC:     taken = ~flag_c;
            CC_C:      taken = flag_c;
            default:   taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/xfer_target.sv
module xfer_target
    import xfer_pkg::*;
#(
    parameter int AW    = 16,
    parameter int REL_W = 8
) (
    input  logic [1:0]    kind,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] imm,
    input  logic [AW-1:0] hl,
    output logic [AW-1:0] target
);
    localparam int EXT_W = AW - REL_W;

    logic [AW-1:0] rel_ext;

    generate
        if (EXT_W > 0) begin : g_ext
            assign rel_ext = {{EXT_W{imm[REL_W-1]}}, imm[REL_W-1:0]};
        end else begin : g_noext
            assign rel_ext = imm;
        end
    endgenerate

    always_comb begin
        unique case (kind_e'(kind))
            K_JREL:  target = pc + rel_ext;
            K_JABS:  target = imm;
            K_JHL:   target = hl;
            default: target = pc;
        endcase
    end
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
    import xfer_pkg::*;
#(
    parameter int AW          = 16,
    parameter int TW          = 5,
    parameter int T_JMP_TAKEN = 12,
    parameter int T_JMP_SKIP  = 8,
    parameter int T_RET_TAKEN = 20,
    parameter int T_RET_SKIP  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [1:0]      req_kind,
    input  logic [2:0]      req_cond,
    input  logic [AW-1:0]   req_imm,
    input  logic [AW-1:0]   pc_in,
    input  logic [AW-1:0]   sp_in,
    input  logic [AW-1:0]   hl_in,
    input  logic            flag_z,
    input  logic            flag_c,
    output logic            mem_rd_en,
    output logic [AW-1:0]   mem_rd_addr,
    input  logic            mem_rd_valid,
    input  logic [AW/2-1:0] mem_rd_data,
    output logic            idle,
    output logic            done,
    output logic [AW-1:0]   pc_out,
    output logic [AW-1:0]   sp_out,
    output logic [TW-1:0]   ticks,
    output logic [TW-3:0]   mcyc
);
    localparam int BYTE_W = AW / 2;
    localparam logic [TW-1:0] TK_JT = TW'(T_JMP_TAKEN);
    localparam logic [TW-1:0] TK_JS = TW'(T_JMP_SKIP);
    localparam logic [TW-1:0] TK_RT = TW'(T_RET_TAKEN);
    localparam logic [TW-1:0] TK_RS = TW'(T_RET_SKIP);

    state_e            state, nxt;
    logic              taken;
    logic [AW-1:0]     target;
    logic [AW-1:0]     pc_q, sp_q;
    logic [TW-1:0]     ticks_q;
    logic [BYTE_W-1:0] lo_q;
    logic              is_ret;

    assign is_ret = (kind_e'(req_kind) == K_RET);

    xfer_cond_eval u_cond (
        .cond   (req_cond),
        .flag_z (flag_z),
        .flag_c (flag_c),
        .taken  (taken)
    );

    xfer_target #(.AW(AW), .REL_W(8)) u_tgt (
        .kind   (req_kind),
        .pc     (pc_in),
        .imm    (req_imm),
        .hl     (hl_in),
        .target (target)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (req_valid) nxt = (is_ret && taken) ? ST_RD_LO : ST_FIN;
            ST_RD_LO:   nxt = ST_WAIT_LO;
            ST_WAIT_LO: if (mem_rd_valid) nxt = ST_RD_HI;
            ST_RD_HI:   nxt = ST_WAIT_HI;
            ST_WAIT_HI: if (mem_rd_valid) nxt = ST_FIN;
            ST_FIN:     nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q    <= '0;
            sp_q    <= '0;
            ticks_q <= '0;
            lo_q    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        sp_q <= sp_in;
                        if (is_ret) begin
                            pc_q    <= pc_in;
                            ticks_q <= taken ? TK_RT : TK_RS;
                        end else begin
                            pc_q    <= taken ? target : pc_in;
                            ticks_q <= taken ? TK_JT : TK_JS;
                        end
                    end
                end
                ST_WAIT_LO: begin
                    if (mem_rd_valid) begin
                        lo_q <= mem_rd_data;
                        sp_q <= sp_q + 1'b1;
                    end
                end
                ST_WAIT_HI: begin
                    if (mem_rd_valid) begin
                        pc_q <= {mem_rd_data, lo_q};
                        sp_q <= sp_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        idle        = (state == ST_IDLE);
        done        = (state == ST_FIN);
        mem_rd_en   = (state == ST_RD_LO) || (state == ST_RD_HI);
        mem_rd_addr = sp_q;
        pc_out      = pc_q;
        sp_out      = sp_q;
        ticks       = ticks_q;
        mcyc        = ticks_q[TW-1:2];
    end
endmodule

// File: rtl/xfer_seq_chk.sv
module xfer_seq_chk #(
    parameter int AW          = 16,
    parameter int TW          = 5,
    parameter int T_JMP_TAKEN = 12,
    parameter int T_JMP_SKIP  = 8,
    parameter int T_RET_TAKEN = 20,
    parameter int T_RET_SKIP  = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_rd_en,
    input logic [AW-1:0] mem_rd_addr,
    input logic          idle,
    input logic          done,
    input logic [TW-1:0] ticks
);
    logic [1:0]    rd_cnt;
    logic [AW-1:0] first_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_cnt     <= '0;
            first_addr <= '0;
        end else if (done) begin
            rd_cnt <= '0;
        end else if (mem_rd_en) begin
            rd_cnt     <= rd_cnt + 1'b1;
            first_addr <= mem_rd_addr;
        end
    end

    // R9
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    a_r6_second_read_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && rd_cnt == 2'd1) |-> (mem_rd_addr == AW'(first_addr + 1'b1)));

    // R7
    a_r7_reads_match_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((rd_cnt == 2'd2) == (ticks == TW'(T_RET_TAKEN))));

    // R5
    a_r5_ticks_legal: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ticks == TW'(T_JMP_TAKEN) || ticks == TW'(T_JMP_SKIP) ||
                  ticks == TW'(T_RET_TAKEN) || ticks == TW'(T_RET_SKIP)));

    // R10
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!mem_rd_en && !done));
endmodule

bind xfer_seq xfer_seq_chk #(
    .AW(AW), .TW(TW), .T_JMP_TAKEN(T_JMP_TAKEN), .T_JMP_SKIP(T_JMP_SKIP),
    .T_RET_TAKEN(T_RET_TAKEN), .T_RET_SKIP(T_RET_SKIP)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .idle(idle), .done(done), .ticks(ticks)
);

// File: tb/sim_xfer_seq.sv
module sim_xfer_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [2:0]  req_cond = '0;
    logic [15:0] req_imm = '0, pc_in = '0, sp_in = '0, hl_in = '0;
    logic        flag_z = 1'b0, flag_c = 1'b0;
    logic        mem_rd_en;
    logic [15:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [7:0]  mem_rd_data = '0;
    logic        idle, done;
    logic [15:0] pc_out, sp_out;
    logic [4:0]  ticks;
    logic [2:0]  mcyc;

    int checks = 0;
    int errors = 0;
    int mem_lat = 1;

    always #5 clk = ~clk;

    xfer_seq u0 (.*);

    typedef struct {
        logic [15:0] pc;
        logic [15:0] sp;
        int          tk;
        int          rd;
        int          rq;
    } exp_t;
    exp_t sbq[$];

    function automatic logic [7:0] memf(input logic [15:0] a);
        return a[7:0] ^ {a[3:0], a[15:12]} ^ 8'hC3;
    endfunction

    // memory model with programmable latency
    logic        pend = 1'b0;
    int          lat_cnt = 0;
    logic [15:0] pend_addr = '0;
    int          rd_total = 0;
    always @(posedge clk) begin
        mem_rd_valid <= 1'b0;
        if (mem_rd_en) begin
            rd_total  <= rd_total + 1;
            pend      <= 1'b1;
            pend_addr <= mem_rd_addr;
            lat_cnt   <= mem_lat - 1;
        end else if (pend) begin
            if (lat_cnt == 0) begin
                mem_rd_valid <= 1'b1;
                mem_rd_data  <= memf(pend_addr);
                pend         <= 1'b0;
            end else begin
                lat_cnt <= lat_cnt - 1;
            end
        end
    end

    task automatic chk(input bit ok, input int rq, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    function automatic bit cond_ok(input logic [2:0] c, input logic z, input logic cy);
        case (c)
            3'd0: return 1'b1;
            3'd1: return !z;
            3'd2: return z;
            3'd3: return !cy;
            3'd4: return cy;
            default: return 1'b0;
        endcase
    endfunction

    // monitor: pops expectations on each done pulse
    int  rd_mark = 0;
    bit  prev_done = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_done && done) chk(1'b0, 9, "done longer than one cycle", 1, 0); // R9
            if (done) begin
                if (sbq.size() == 0) begin
                    chk(1'b0, 10, "unexpected result", 1, 0); // R10
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    chk(pc_out == e.pc, e.rq, "pc", pc_out, e.pc);
                    chk(sp_out == e.sp, e.rq, "sp", sp_out, e.sp);
                    chk(ticks == e.tk, e.rq, "ticks", ticks, e.tk);
                    chk(mcyc == e.tk / 4, 8, "mcyc", mcyc, e.tk / 4); // R8
                    chk(rd_total - rd_mark == e.rd, e.rq, "reads", rd_total - rd_mark, e.rd);
                end
                rd_mark = rd_total;
            end
        end
        prev_done = done;
    end

    // driver: computes expectation, pushes it, drives one request
    task automatic issue(input logic [1:0] k, input logic [2:0] c, input logic [15:0] imm,
                         input logic [15:0] pc, input logic [15:0] sp, input logic [15:0] hl,
                         input logic z, input logic cy, input int rq, input bit poke);
        exp_t e;
        bit tk;
        tk   = cond_ok(c, z, cy);
        e.rq = rq;
        e.sp = sp;
        e.pc = pc;
        e.rd = 0;
        if (k == 2'd3) begin
            e.tk = tk ? 20 : 8;
            if (tk) begin
                e.pc = {memf(sp + 16'd1), memf(sp)};
                e.sp = sp + 16'd2;
                e.rd = 2;
            end
        end else begin
            e.tk = tk ? 12 : 8;
            if (tk) begin
                if (k == 2'd0)      e.pc = pc + {{8{imm[7]}}, imm[7:0]};
                else if (k == 2'd1) e.pc = imm;
                else                e.pc = hl;
            end
        end
        sbq.push_back(e);
        @(negedge clk);
        while (!idle) @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_cond = c; req_imm = imm;
        pc_in = pc; sp_in = sp; hl_in = hl; flag_z = z; flag_c = cy;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            // R10: request while busy must be ignored
            req_valid = 1'b1; req_kind = 2'd1; req_cond = 3'd0; req_imm = 16'hDEAD;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (!idle) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, 0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(idle == 1'b1, 1, "idle at reset", idle, 1);
        chk(done == 1'b0, 1, "done at reset", done, 0);
        chk(mem_rd_en == 1'b0, 1, "read at reset", mem_rd_en, 0);
        chk(pc_out == 16'h0 && sp_out == 16'h0, 1, "pc/sp at reset", pc_out, 0);
        chk(ticks == 5'd0, 1, "ticks at reset", ticks, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 relative jumps, forward/backward/wrap
        issue(2'd0, 3'd0, 16'h0010, 16'h1000, 16'h8000, 16'h0, 0, 0, 3, 0);
        issue(2'd0, 3'd0, 16'h00F0, 16'h1000, 16'h8000, 16'h0, 0, 0, 3, 0);
        issue(2'd0, 3'd0, 16'h0010, 16'hFFF8, 16'h8000, 16'h0, 0, 0, 3, 0);
        issue(2'd0, 3'd0, 16'hAA80, 16'h0002, 16'h8000, 16'h0, 0, 0, 3, 0);

        // R2 every condition code against every flag combination (absolute jump, R4/R5)
        for (int c = 0; c < 8; c++)
            for (int f = 0; f < 4; f++)
                issue(2'd1, 3'(c), 16'h4321, 16'h0200, 16'h7000, 16'h0, f[0], f[1], 2, 0);

        // R4 jump via HL, taken and not taken
        issue(2'd2, 3'd2, 16'h0, 16'h0300, 16'h1234, 16'hBEEF, 1, 0, 4, 0);
        issue(2'd2, 3'd2, 16'h0, 16'h0300, 16'h1234, 16'hBEEF, 0, 0, 5, 0);

        // R6 taken returns, including SP wrap
        issue(2'd3, 3'd0, 16'h0, 16'h0400, 16'hC000, 16'h0, 0, 0, 6, 0);
        issue(2'd3, 3'd3, 16'h0, 16'h0400, 16'hFFFF, 16'h0, 0, 0, 6, 0);
        // R7 not-taken return
        issue(2'd3, 3'd4, 16'h0, 16'h0500, 16'hD000, 16'h0, 0, 0, 7, 0);
        issue(2'd3, 3'd6, 16'h0, 16'h0500, 16'hD000, 16'h0, 1, 1, 7, 0);

        // R11 slow memory
        mem_lat = 4;
        issue(2'd3, 3'd1, 16'h0, 16'h0600, 16'hABCD, 16'h0, 0, 0, 11, 0);
        mem_lat = 1;

        // R10 request during a busy return
        issue(2'd3, 3'd0, 16'h0, 16'h0700, 16'h2222, 16'h0, 0, 0, 10, 1);

        repeat (5) @(negedge clk);
        chk(sbq.size() == 0, 9, "missing results", sbq.size(), 0);
        finish_run();
    end
endmodule